// File: doc/BRIEF.md
# Keyed Sector-Program Sequencer

This block models, clock by clock, the write-side control of a byte-wide memory that is programmed one whole sector at a time. The memory uses 18-bit addresses. A host drives a plain asynchronous-style bus: address, write data, and active-low chip-enable, output-enable and write-enable. The block samples these on every clock. A three-write key opens a load window. The bytes written in that window collect in a sector-sized buffer. When the bus has been quiet for a set number of cycles, the block erases the addressed sector of its internal array and then writes the collected bytes into it.

While the erase-and-program cycle runs, `busy` is high and every read returns a status byte instead of array data, so software can poll for completion. A write that does not start the key sequence stores nothing, but it still holds the device busy for one full cycle. All timing is counted in clock cycles set by parameters. The array holds `ARRAY_SECTORS` sectors. The low bits of the sector field select one of them, so higher sector numbers alias onto those.

Top module: `sector_prog_seq`

## Requirements
- R1: After reset, `busy` is 0. `rdata` is 0x00 whenever no read is in progress. Every array byte reads back as 0xFF.
- R2: A bus write counts only while `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe with `oe_n` low or with `ce_n` high has no effect: `busy` stays 0 and the array is unchanged.
- R3: Each write takes its address from the first sampled cycle in which the write is active. It takes its data from the first sampled cycle after the write ends. An address change in mid-strobe is therefore ignored, and a data change in mid-strobe is used.
- R4: A program operation opens only after three writes in a row: 0xAA to 0x05555, then 0x55 to 0x02AAA, then 0xA0 to 0x05555. Every program operation needs the whole key again.
- R5: A key write with the wrong address or data sends the sequencer back to idle. It starts no busy period and programs nothing.
- R6: In idle, a write that is not the first key write stores no data. `busy` rises 2 clock edges after the strobe ends and stays high for exactly `WC_CYCLES` cycles.
- R7: During the load window, address bits [7:0] pick the byte within the buffer and bits [17:8] pick the sector. Bytes may arrive in any order. The array sector used is the sector field modulo `ARRAY_SECTORS`.
- R8: The load window closes when no write has been active for `LOAD_CYCLES` cycles after the last write ended. `busy` then rises `LOAD_CYCLES`+2 edges after that strobe ended. If no byte was loaded, the sequencer returns to idle without going busy.
- R9: A program cycle lasts exactly `WC_CYCLES` cycles. It sets every byte of the addressed array sector to 0xFF first, then writes the loaded bytes. Bytes that were not loaded read back 0xFF, and other sectors are not changed.
- R10: A load whose sector field differs from that of the first loaded byte is ignored, and the first sector is kept.
- R11: A read is active while `ce_n`=0, `oe_n`=0 and `we_n`=1, and its result appears 2 clock edges after the inputs are applied. When `busy` is high, the result is a status byte: bit 7 is the inverse of bit 7 of the last accepted data, bit 6 flips on each new read, and bits [5:0] equal bits [5:0] of the last accepted data. When `busy` is low, the result is the array byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 18 | Byte address |
| wdata | input | 8 | Write data |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rdata | output | 8 | Read data or status byte, 0x00 when not reading |
| busy | output | 1 | High during an erase/program or write-timer period |

## Verification
The bench counts rising clock edges. For each strobe, it records the edge count at the moment the strobe is released. `busy` must be low at release+1 and high at release+2 after a stray write (R6). After the final load, `busy` must be low at release+`LOAD_CYCLES`+1 and high one edge later (R8). It must fall exactly `WC_CYCLES` edges after it rose (R9). Read results are sampled on the falling edge that follows the second rising edge after the read inputs are applied (R11). Each check waits for its stated edge count before it samples, so an off-by-one in any register stage or counter compare shows up as a failure.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_LOAD,
        ST_BUSY
    } sps_state_e;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_DATA_1 = 8'hAA;
    localparam logic [7:0]  KEY_DATA_2 = 8'h55;
    localparam logic [7:0]  KEY_DATA_3 = 8'hA0;

endpackage

// File: rtl/sps_strobe.sv
module sps_strobe #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    output logic              wr_evt_o,
    output logic              wr_act_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_act_o,
    output logic              rd_start_o,
    output logic [ADDR_W-1:0] rd_addr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              wr_prev;
        logic              rd_prev;
        logic [ADDR_W-1:0] cap_addr;
    } smp_t;

    smp_t smp_d, smp_q;
    logic cur_wr, cur_rd;

    always_comb begin
        cur_wr = !smp_q.ce_n && !smp_q.we_n && smp_q.oe_n;
        cur_rd = !smp_q.ce_n && !smp_q.oe_n && smp_q.we_n;

        smp_d         = smp_q;
        smp_d.addr    = addr_i;
        smp_d.data    = data_i;
        smp_d.ce_n    = ce_n_i;
        smp_d.oe_n    = oe_n_i;
        smp_d.we_n    = we_n_i;
        smp_d.wr_prev = cur_wr;
        smp_d.rd_prev = cur_rd;
        // address taken when the later strobe goes active
        if (cur_wr && !smp_q.wr_prev) begin
            smp_d.cap_addr = smp_q.addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q      <= '0;
            smp_q.ce_n <= 1'b1;
            smp_q.oe_n <= 1'b1;
            smp_q.we_n <= 1'b1;
        end else begin
            smp_q <= smp_d;
        end
    end

    // data taken on the first sample after either strobe releases
    assign wr_evt_o   = !cur_wr && smp_q.wr_prev;
    assign wr_act_o   = cur_wr || smp_q.wr_prev;
    assign wr_addr_o  = smp_q.cap_addr;
    assign wr_data_o  = smp_q.data;
    assign rd_act_o   = cur_rd;
    assign rd_start_o = cur_rd && !smp_q.rd_prev;
    assign rd_addr_o  = smp_q.addr;

endmodule

// File: rtl/sps_sector_buf.sv
module sps_sector_buf #(
    parameter int BYTES  = 256,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ld_i,
    input  logic [IDX_W-1:0]  ld_idx_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);

    logic [BYTES-1:0]  mask_d, mask_q;
    logic [DATA_W-1:0] store [BYTES];

    always_comb begin
        mask_d = mask_q;
        if (clr_i) begin
            mask_d = '0;
        end else if (ld_i) begin
            mask_d[ld_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_i) begin
            store[ld_idx_i] <= ld_data_i;
        end
    end

    assign rd_data_o  = store[rd_idx_i];
    assign rd_valid_o = mask_q[rd_idx_i];

endmodule

// File: rtl/sps_array.sv
module sps_array #(
    parameter int SECTORS = 4,
    parameter int BYTES   = 256,
    parameter int DATA_W  = 8,
    localparam int DEPTH  = SECTORS * BYTES,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/sector_prog_seq.sv
module sector_prog_seq
    import sps_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8,
    parameter int SECTOR_BYTES  = 256,
    parameter int ARRAY_SECTORS = 4,
    parameter int LOAD_CYCLES   = 40,
    parameter int WC_CYCLES     = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);

    localparam int BYTE_W  = $clog2(SECTOR_BYTES);
    localparam int SEC_W   = ADDR_W - BYTE_W;
    localparam int SIDX_W  = $clog2(ARRAY_SECTORS);
    localparam int MEM_W   = SIDX_W + BYTE_W;
    localparam int CNT_MAX = (LOAD_CYCLES > WC_CYCLES) ? LOAD_CYCLES : WC_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LOAD_LAST  = CNT_W'(LOAD_CYCLES - 1);
    localparam logic [CNT_W-1:0] WC_LAST    = CNT_W'(WC_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_END  = CNT_W'(SECTOR_BYTES);
    localparam logic [CNT_W-1:0] PROG_END   = CNT_W'(2 * SECTOR_BYTES);
    localparam logic [ADDR_W-1:0] KA = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] KB = ADDR_W'(KEY_ADDR_B);

    typedef struct packed {
        sps_state_e        state;
        logic [SEC_W-1:0]  sector;
        logic              have;
        logic [CNT_W-1:0]  cnt;
        logic              do_prog;
        logic [DATA_W-1:0] last_data;
        logic              toggle;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              wr_evt, wr_act, rd_act, rd_start;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data;
    logic [SEC_W-1:0]  wr_sector;
    logic              key1, key2, key3;

    logic              buf_clr, buf_ld, buf_valid;
    logic [DATA_W-1:0] buf_data;

    logic              mem_we;
    logic [MEM_W-1:0]  mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [DATA_W-1:0] status;

    sps_strobe #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .data_i     (wdata),
        .ce_n_i     (ce_n),
        .oe_n_i     (oe_n),
        .we_n_i     (we_n),
        .wr_evt_o   (wr_evt),
        .wr_act_o   (wr_act),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .rd_act_o   (rd_act),
        .rd_start_o (rd_start),
        .rd_addr_o  (rd_addr)
    );

    sps_sector_buf #(
        .BYTES  (SECTOR_BYTES),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (buf_clr),
        .ld_i       (buf_ld),
        .ld_idx_i   (wr_addr[BYTE_W-1:0]),
        .ld_data_i  (wr_data),
        .rd_idx_i   (ctl_q.cnt[BYTE_W-1:0]),
        .rd_data_o  (buf_data),
        .rd_valid_o (buf_valid)
    );

    sps_array #(
        .SECTORS (ARRAY_SECTORS),
        .BYTES   (SECTOR_BYTES),
        .DATA_W  (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    assign wr_sector = wr_addr[ADDR_W-1:BYTE_W];
    assign key1 = (wr_addr == KA) && (wr_data == DATA_W'(KEY_DATA_1));
    assign key2 = (wr_addr == KB) && (wr_data == DATA_W'(KEY_DATA_2));
    assign key3 = (wr_addr == KA) && (wr_data == DATA_W'(KEY_DATA_3));
    assign mem_raddr = {rd_addr[BYTE_W +: SIDX_W], rd_addr[BYTE_W-1:0]};

    logic unused_bits;
    assign unused_bits = ^{rd_addr[ADDR_W-1:BYTE_W+SIDX_W], ctl_q.last_data[DATA_W-2]};

    always_comb begin
        ctl_d     = ctl_q;
        mem_we    = 1'b0;
        mem_waddr = {ctl_q.sector[SIDX_W-1:0], ctl_q.cnt[BYTE_W-1:0]};
        mem_wdata = '1;
        buf_clr   = 1'b0;
        buf_ld    = 1'b0;

        case (ctl_q.state)
            ST_IDLE: begin
                if (wr_evt) begin
                    if (key1) begin
                        ctl_d.state = ST_KEY1;
                    end else begin
                        // stray write: timer only, nothing stored
                        ctl_d.state     = ST_BUSY;
                        ctl_d.cnt       = '0;
                        ctl_d.do_prog   = 1'b0;
                        ctl_d.last_data = wr_data;
                    end
                end
            end
            ST_KEY1: begin
                if (wr_evt) begin
                    ctl_d.state = key2 ? ST_KEY2 : ST_IDLE;
                end
            end
            ST_KEY2: begin
                if (wr_evt) begin
                    if (key3) begin
                        ctl_d.state = ST_LOAD;
                        ctl_d.cnt   = '0;
                        ctl_d.have  = 1'b0;
                        buf_clr     = 1'b1;
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            ST_LOAD: begin
                if (wr_act) begin
                    ctl_d.cnt = '0;
                end else if (ctl_q.cnt == LOAD_LAST) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.have) begin
                        ctl_d.state   = ST_BUSY;
                        ctl_d.do_prog = 1'b1;
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
                if (wr_evt && (!ctl_q.have || (wr_sector == ctl_q.sector))) begin
                    buf_ld          = 1'b1;
                    ctl_d.have      = 1'b1;
                    ctl_d.sector    = wr_sector;
                    ctl_d.last_data = wr_data;
                end
            end
            ST_BUSY: begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (ctl_q.do_prog) begin
                    if (ctl_q.cnt < ERASE_END) begin
                        mem_we    = 1'b1;
                        mem_wdata = '1;
                    end else if (ctl_q.cnt < PROG_END) begin
                        mem_we    = buf_valid;
                        mem_wdata = buf_data;
                    end
                end
                if (ctl_q.cnt == WC_LAST) begin
                    ctl_d.state   = ST_IDLE;
                    ctl_d.cnt     = '0;
                    ctl_d.do_prog = 1'b0;
                    ctl_d.have    = 1'b0;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase

        if (rd_start && (ctl_q.state == ST_BUSY)) begin
            ctl_d.toggle = ~ctl_q.toggle;
        end
        status = {~ctl_q.last_data[DATA_W-1], ctl_d.toggle, ctl_q.last_data[DATA_W-3:0]};
        if (!rd_act) begin
            ctl_d.rdata = '0;
        end else if (ctl_q.state == ST_BUSY) begin
            ctl_d.rdata = status;
        end else begin
            ctl_d.rdata = mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdata = ctl_q.rdata;
    assign busy  = (ctl_q.state == ST_BUSY);

endmodule

// File: rtl/sps_checker.sv
module sps_checker
    import sps_pkg::*;
#(
    parameter int WC_CYCLES = 600,
    parameter int SEC_W     = 10,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              busy,
    input logic [DATA_W-1:0] rdata,
    input logic              mem_we,
    input sps_state_e        st,
    input logic              have,
    input logic [SEC_W-1:0]  sector
);

    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else begin
            run_q <= busy ? run_q + 1 : 0;
        end
    end

    // R6 / R9: every busy period spans exactly WC_CYCLES cycles
    a_r9_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == WC_CYCLES));

    // R9: array cells change only inside a busy period
    a_r9_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R10: once a sector is taken, it stays for the rest of the load
    a_r10_sector_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD && have) |=> (st != ST_LOAD || $stable(sector)));

    // R1 / R11: no read selected two edges back means an all-zero output
    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n, 2) |-> (rdata == '0));

endmodule

bind sector_prog_seq sps_checker #(
    .WC_CYCLES (WC_CYCLES),
    .SEC_W     (SEC_W),
    .DATA_W    (DATA_W)
) u_sps_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .busy   (busy),
    .rdata  (rdata),
    .mem_we (mem_we),
    .st     (ctl_q.state),
    .have   (ctl_q.have),
    .sector (ctl_q.sector)
);

// File: tb/sector_prog_seq_bench.sv
module sector_prog_seq_bench;

    localparam int L  = 40;
    localparam int WC = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [7:0]  rdata;
    logic        busy;

    int n_tests = 0;
    int n_fail  = 0;
    int pcnt    = 0;
    int rel     = 0;
    bit done    = 1'b0;

    sector_prog_seq #(
        .LOAD_CYCLES (L),
        .WC_CYCLES   (WC)
    ) u_sector_prog_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .rdata (rdata),
        .busy  (busy)
    );

    always #5 clk = ~clk;
    always @(posedge clk) pcnt <= pcnt + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_pc(input int n);
        while (pcnt < n) @(negedge clk);
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        rel = pcnt;
    endtask

    task automatic wr_skew(input logic [17:0] a1, input logic [7:0] d1,
                           input logic [17:0] a2, input logic [7:0] d2);
        @(negedge clk);
        addr = a1; wdata = d1; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = a2; wdata = d2;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        rel = pcnt;
    endtask

    task automatic rd(input logic [17:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        v = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic unlock();
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(18'h05555, 8'hA0);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 busy after reset", busy, 0);
        chk("R1 rdata idle", rdata, 8'h00);
        rd(18'h00123, v);
        chk("R1 erased array", v, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R1 rdata after read", rdata, 8'h00);
    endtask

    task automatic t_inhibit();
        logic [7:0] v;
        @(negedge clk);
        addr = 18'h00040; wdata = 8'h11; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 oe low inhibits", busy, 0);
        addr = 18'h00041; ce_n = 1'b1; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 ce high inhibits", busy, 0);
        rd(18'h00040, v);
        chk("R2 array untouched", v, 8'hFF);
    endtask

    task automatic t_stray_write();
        logic [7:0] s1, s2, v;
        int r;
        wr(18'h00010, 8'h77);
        r = rel;
        wait_pc(r + 1);
        chk("R6 busy not yet", busy, 0);
        wait_pc(r + 2);
        chk("R6 busy rises", busy, 1);
        rd(18'h00010, s1);
        rd(18'h00010, s2);
        chk("R11 poll bit7", s1[7], 1);
        chk("R11 poll low bits", s1[5:0], 6'h37);
        chk("R11 toggle flips", s1[6] ^ s2[6], 1);
        wait_pc(r + WC + 1);
        chk("R6 busy held", busy, 1);
        wait_pc(r + WC + 2);
        chk("R6 busy ends", busy, 0);
        rd(18'h00010, v);
        chk("R6 no data stored", v, 8'hFF);
    endtask

    task automatic t_program_one();
        logic [7:0] v;
        int r;
        unlock();
        wr(18'h00206, 8'h12);
        r = rel;
        wait_pc(r + L + 1);
        chk("R8 window still open", busy, 0);
        wait_pc(r + L + 2);
        chk("R8 window closes", busy, 1);
        wait_pc(r + L + 1 + WC);
        chk("R9 busy full length", busy, 1);
        wait_pc(r + L + 2 + WC);
        chk("R9 busy ends", busy, 0);
        rd(18'h00206, v);
        chk("R4 programmed byte", v, 8'h12);
    endtask

    task automatic t_program_multi();
        logic [7:0] v;
        int r;
        unlock();
        wr(18'h002F0, 8'hC3);
        wr(18'h0030A, 8'h99);
        wr(18'h00205, 8'h3C);
        wr_skew(18'h00210, 8'hA5, 18'h00211, 8'h5A);
        wr(18'h00200, 8'h81);
        r = rel;
        wait_pc(r + L + 3);
        rd(18'h00000, v);
        chk("R11 poll bit7 after 0x81", v[7], 0);
        chk("R11 poll low bits after 0x81", v[5:0], 6'h01);
        wait_pc(r + L + 2 + WC);
        chk("R9 busy ends multi", busy, 0);
        rd(18'h002F0, v); chk("R7 byte 0xF0", v, 8'hC3);
        rd(18'h00205, v); chk("R7 byte 0x05", v, 8'h3C);
        rd(18'h00200, v); chk("R7 byte 0x00", v, 8'h81);
        rd(18'h00206, v); chk("R9 unloaded byte erased", v, 8'hFF);
        rd(18'h00210, v); chk("R3 start addr late data", v, 8'h5A);
        rd(18'h00211, v); chk("R3 mid-strobe addr ignored", v, 8'hFF);
        rd(18'h0030A, v); chk("R10 other sector ignored", v, 8'hFF);
        rd(18'h00010, v); chk("R9 other sector kept", v, 8'hFF);
    endtask

    task automatic t_broken_key();
        logic [7:0] v;
        int r;
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(18'h05556, 8'hA0);
        r = rel;
        wait_pc(r + 3);
        chk("R5 bad third key no busy", busy, 0);
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h54);
        r = rel;
        wait_pc(r + 3);
        chk("R5 bad second key no busy", busy, 0);
        wr(18'h00300, 8'h11);
        r = rel;
        wait_pc(r + 2);
        chk("R4 write without key is stray", busy, 1);
        wait_pc(r + WC + 2);
        chk("R4 stray busy ends", busy, 0);
        rd(18'h00300, v);
        chk("R4 nothing programmed", v, 8'hFF);
    endtask

    task automatic t_empty_load();
        int r;
        unlock();
        r = rel;
        wait_pc(r + L + 5);
        chk("R8 empty window no busy", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inhibit();
        t_stray_write();
        t_program_one();
        t_program_multi();
        t_broken_key();
        t_empty_load();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule